// File: doc/BRIEF.md
# SMBus Target with Alert Response

This block is the serial management port of a small peripheral. It watches the two SMBus lines, finds START and STOP conditions, and matches the first byte of each transfer against its own 7-bit address. That address is one of two fixed values, picked by a strap input. After a match it acknowledges each byte. On a write, the first data byte loads a register pointer and each later byte is stored in a small register file. On a read, the block shifts register contents out most significant bit first. The block never drives the clock line. It drives the data line only low, shown as an output enable that the pad turns into an open-drain pull-down.

The block also has an active-low alert output, raised by a request pulse from the logic behind the registers. While alert is asserted, the block also acknowledges a read to the shared alert response address. It answers with its own address byte and then withdraws the alert. When alert is not asserted, that address is left unacknowledged.

Both bus lines are sampled in the system clock domain through synchronisers. The controller has eight named states:
- ST_IDLE waits for a START.
- ST_ADDR shifts in the address byte.
- ST_ADDR_ACK drives the address acknowledge.
- ST_WR_BYTE shifts in a written byte.
- ST_WR_ACK drives its acknowledge.
- ST_RD_BYTE shifts a byte out.
- ST_RD_ACK samples the host's acknowledge.
- ST_SKIP ignores the bus until the next START or STOP.

The transitions are:
- Any state goes to ST_ADDR on START and to ST_IDLE on STOP.
- ST_ADDR goes to ST_ADDR_ACK on a match, or to ST_SKIP on a mismatch, at the falling clock edge after the eighth bit.
- ST_ADDR_ACK goes to ST_WR_BYTE or ST_RD_BYTE, depending on the direction bit, at the end of the ninth clock.
- ST_WR_BYTE goes to ST_WR_ACK after eight bits, and ST_WR_ACK returns to ST_WR_BYTE after the ninth clock.
- ST_RD_BYTE goes to ST_RD_ACK after the eighth falling edge.
- ST_RD_ACK goes to ST_RD_BYTE if the host acknowledged, or to ST_SKIP on a host NACK.

Top module: `smb_target`

## Requirements
- R1: After reset, sda_oe is 0, alert_n is 1 and every register in regs_o reads 0x00.
- R2: A START (data falling while clock is high) followed by the byte {7'b0101110, direction}, with addr_sel = 0, is acknowledged by driving data low for the ninth clock. Direction 0 means a write and 1 means a read; bytes are shifted most significant bit first.
- R3: An address byte that matches neither the selected own address nor an active alert response is not acknowledged, and the data bytes after it change no register.
- R4: With addr_sel = 1 the own address is 7'b0101111 and 7'b0101110 is no longer acknowledged.
- R5: In a write, the first data byte sets the pointer. Each later byte is stored in register pointer mod REG_COUNT (regs_o bits [8*i+7:8*i] hold register i), and the pointer then advances by one. Every data byte is acknowledged.
- R6: In a read, the block sends the register at the pointer, most significant bit first. The pointer advances after each byte sent, and the block keeps sending while the host acknowledges.
- R7: After the host leaves data high in the acknowledge slot of a read, the block stops driving data until the next START.
- R8: A pulse on alert_set drives alert_n low from the next cycle. The read address {7'b0001100, 1} is acknowledged only while alert_n is low.
- R9: A read to the alert response address returns {own address, 1'b0}. After that byte's acknowledge slot, alert_n returns to 1.
- R10: sda_oe changes only while the clock line is low.
- R11: A repeated START inside a transfer restarts address decoding. The pointer loaded before it is used by a following read.
- R12: A STOP returns the block to idle and releases data. Clock pulses that follow without a START get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Address strap: 0 selects 7'b0101110, 1 selects 7'b0101111 |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| alert_set | input | 1 | One-cycle request to assert the alert |
| alert_n | output | 1 | Active-low alert |
| regs_o | output | REG_COUNT*8 | Register file contents, register i at bits [8*i+7:8*i] |

## Verification
Address bytes are sent in four kinds: the main own address, the strapped alternate, a foreign address, and the alert response address with alert both asserted and not asserted. Together these separate a correct match decision from one that acknowledges too much or too little. Writes with two data bytes followed by a read through a repeated START show whether the pointer load, the auto-increment and the read-side increment each happen once and in the right order. A read ending in NACK, followed by extra clock pulses, and clock pulses sent after a STOP without a START show whether the block truly releases the line.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;

    localparam logic [6:0] MAIN_ADDR_DEF  = 7'b0101110;
    localparam logic [6:0] ALT_ADDR_DEF   = 7'b0101111;
    localparam logic [6:0] ALERT_ADDR_DEF = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } smb_state_e;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    localparam int PIPE_W = 2 * STAGES;

    // each stage holds {scl, sda}; idle bus level is high
    logic [PIPE_W-1:0] pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q     <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            pipe_q     <= {pipe_q[PIPE_W-3:0], scl_i, sda_i};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s    = pipe_q[PIPE_W-1];
    assign sda_s    = pipe_q[PIPE_W-2];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int REG_COUNT = 8,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [DATA_W-1:0]           rd_data,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] word_q [REG_COUNT];

    generate
        for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q[g] <= '0;
                end else if (wr_en && (int'(wr_idx) == g)) begin
                    word_q[g] <= wr_data;
                end
            end
            assign regs_o[g*DATA_W +: DATA_W] = word_q[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (int'(rd_idx) == i) begin
                rd_data = word_q[i];
            end
        end
    end

endmodule

// File: rtl/smb_target.sv
module smb_target
    import smb_pkg::*;
#(
    parameter int         REG_COUNT   = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] MAIN_ADDR   = MAIN_ADDR_DEF,
    parameter logic [6:0] ALT_ADDR    = ALT_ADDR_DEF,
    parameter logic [6:0] ALERT_ADDR  = ALERT_ADDR_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        addr_sel,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe,
    input  logic                        alert_set,
    output logic                        alert_n,
    output logic [REG_COUNT*BYTE_W-1:0] regs_o
);

    localparam int IDX_W  = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    // synchronised bus view
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    smb_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [BYTE_W-1:0]   shreg_q;
    logic [BYTE_W-1:0]   ptr_q;
    logic                ptr_valid_q;
    logic                rw_q;
    logic                ara_q;
    logic                host_ack_q;
    logic                sda_oe_q;
    logic                alert_q;

    // decode helpers
    logic [6:0]        own_addr;
    logic              addr_match;
    logic              ara_match;
    logic              byte_done;
    logic              last_fall;
    logic [BYTE_W-1:0] rd_ptr;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] tx_byte;
    logic              wr_en;

    assign own_addr   = addr_sel ? ALT_ADDR : MAIN_ADDR;
    assign addr_match = (shreg_q[BYTE_W-1:1] == own_addr);
    assign ara_match  = (shreg_q[BYTE_W-1:1] == ALERT_ADDR) && shreg_q[0] && alert_q;
    assign byte_done  = scl_fall && (cnt_q == CNT_FULL);
    assign last_fall  = scl_fall && (cnt_q == CNT_LAST);

    // while waiting for the host ack, look ahead at the next register
    assign rd_ptr  = ((state_q == ST_RD_ACK) && !ara_q) ? ptr_q + 1'b1 : ptr_q;
    assign tx_byte = ara_q ? {own_addr, 1'b0} : rd_data;
    assign wr_en   = (state_q == ST_WR_BYTE) && byte_done && ptr_valid_q;

    smb_regfile #(
        .REG_COUNT (REG_COUNT),
        .DATA_W    (BYTE_W),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr_q[IDX_W-1:0]),
        .wr_data (shreg_q),
        .rd_idx  (rd_ptr[IDX_W-1:0]),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_SKIP:     state_d = ST_SKIP;
                ST_ADDR: begin
                    if (byte_done) begin
                        state_d = (addr_match || ara_match) ? ST_ADDR_ACK : ST_SKIP;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                    end
                end
                ST_WR_BYTE: begin
                    if (byte_done) begin
                        state_d = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (last_fall) begin
                        state_d = ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        state_d = host_ack_q ? ST_RD_BYTE : ST_SKIP;
                    end
                end
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            shreg_q     <= '0;
            ptr_q       <= '0;
            ptr_valid_q <= 1'b0;
            rw_q        <= 1'b0;
            ara_q       <= 1'b0;
            host_ack_q  <= 1'b0;
            sda_oe_q    <= 1'b0;
            alert_q     <= 1'b0;
        end else begin
            if (stop_ev || start_ev) begin
                cnt_q    <= '0;
                sda_oe_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_SKIP: begin
                        sda_oe_q <= 1'b0;
                    end
                    ST_ADDR: begin
                        if (scl_rise && (cnt_q != CNT_FULL)) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (byte_done) begin
                            rw_q  <= shreg_q[0];
                            ara_q <= ara_match && !addr_match;
                            if (addr_match || ara_match) begin
                                sda_oe_q <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                shreg_q  <= tx_byte;
                                sda_oe_q <= ~tx_byte[BYTE_W-1];
                            end else begin
                                ptr_valid_q <= 1'b0;
                                sda_oe_q    <= 1'b0;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise && (cnt_q != CNT_FULL)) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (byte_done) begin
                            sda_oe_q <= 1'b1;
                            if (ptr_valid_q) begin
                                ptr_q <= ptr_q + 1'b1;
                            end else begin
                                ptr_q       <= shreg_q;
                                ptr_valid_q <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe_q <= 1'b0;
                            cnt_q    <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (last_fall) begin
                            sda_oe_q <= 1'b0;
                        end else if (scl_fall) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~shreg_q[BYTE_W-2];
                            cnt_q    <= cnt_q + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            host_ack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            cnt_q <= '0;
                            if (ara_q) begin
                                alert_q <= 1'b0;
                            end else begin
                                ptr_q <= ptr_q + 1'b1;
                            end
                            if (host_ack_q) begin
                                shreg_q  <= tx_byte;
                                sda_oe_q <= ~tx_byte[BYTE_W-1];
                            end
                        end
                    end
                    default: sda_oe_q <= 1'b0;
                endcase
            end
            // a new request wins over the clear at the end of a response
            if (alert_set) begin
                alert_q <= 1'b1;
            end
        end
    end

    assign sda_oe  = sda_oe_q;
    assign alert_n = ~alert_q;

endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk
    import smb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       alert_set,
    input logic       alert_n,
    input smb_state_e state,
    input logic       start_ev,
    input logic       stop_ev
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R10

    AST_OE_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_WR_ACK ||
                    state == ST_RD_BYTE  || state == ST_RD_ACK)); // R3

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe && state == ST_IDLE)); // R12

    AST_START_DECODES: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR)); // R11

    AST_ALERT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        alert_set |=> !alert_n); // R8

    AST_ALERT_CLEAR_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_n) |-> ($past(state) == ST_RD_ACK)); // R9

endmodule

bind smb_target smb_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .alert_set (alert_set),
    .alert_n   (alert_n),
    .state     (state_q),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev)
);

// File: tb/smb_target_tb.sv
module smb_target_tb;

    localparam int REG_COUNT = 8;
    localparam int Q         = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst_n;
    logic                    addr_sel;
    logic                    host_scl;
    logic                    host_sda;
    logic                    alert_set;
    logic                    sda_oe;
    logic                    alert_n;
    logic [REG_COUNT*8-1:0]  regs_o;
    logic                    sda_bus;

    assign sda_bus = host_sda & ~sda_oe;

    smb_target #(.REG_COUNT(REG_COUNT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .scl_i     (host_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .alert_set (alert_set),
        .alert_n   (alert_n),
        .regs_o    (regs_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int r10_viol = 0;
    logic oe_prev = 1'b0;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R10 monitor: data enable must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && host_scl) r10_viol++;
        oe_prev <= sda_oe;
    end

    task automatic bus_start();
        host_sda = 1'b1; wait_cyc(Q);
        host_scl = 1'b1; wait_cyc(Q);
        host_sda = 1'b0; wait_cyc(Q);
        host_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_cyc(Q);
        host_scl = 1'b1; wait_cyc(Q);
        host_sda = 1'b1; wait_cyc(Q);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    wait_cyc(Q);
        host_scl = 1'b1; wait_cyc(2 * Q);
        host_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; wait_cyc(Q);
        host_scl = 1'b1; wait_cyc(Q);
        b = sda_bus;     wait_cyc(Q);
        host_scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    function automatic logic [7:0] reg_at(input int idx);
        return regs_o[idx*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 1'b0);
        chk("R1 alert_n", alert_n, 1'b1);
        chk("R1 regs", regs_o, '0);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        send_byte(8'h5C, a); chk("R2 address ack", a, 1'b1);
        send_byte(8'h02, a); chk("R5 pointer ack", a, 1'b1);
        send_byte(8'hA5, a); chk("R5 data ack", a, 1'b1);
        send_byte(8'h3C, a); chk("R5 data ack 2", a, 1'b1);
        bus_stop();
        chk("R5 reg2", reg_at(2), 8'hA5);
        chk("R5 reg3", reg_at(3), 8'h3C);
        chk("R5 reg1 untouched", reg_at(1), 8'h00);
    endtask

    task automatic t_read();
        logic a;
        logic b;
        logic [7:0] d;
        bus_start();
        send_byte(8'h5C, a); chk("R11 write address ack", a, 1'b1);
        send_byte(8'h02, a); chk("R11 pointer ack", a, 1'b1);
        bus_start();
        send_byte(8'h5D, a); chk("R11 read address ack after repeated start", a, 1'b1);
        recv_byte(1'b1, d);  chk("R6 first byte", d, 8'hA5);
        recv_byte(1'b0, d);  chk("R6 second byte", d, 8'h3C);
        chk("R7 released after nack", sda_oe, 1'b0);
        recv_bit(b);         chk("R7 no drive on extra clock", b, 1'b1);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'h5E, a); chk("R3 foreign address nack", a, 1'b0);
        send_byte(8'h00, a);
        send_byte(8'hFF, a); chk("R3 data nack", a, 1'b0);
        bus_stop();
        chk("R3 reg0 unchanged", reg_at(0), 8'h00);
    endtask

    task automatic t_strap();
        logic a;
        addr_sel = 1'b1;
        wait_cyc(4);
        bus_start();
        send_byte(8'h5E, a); chk("R4 alternate address ack", a, 1'b1);
        send_byte(8'h05, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R4 reg5 written", reg_at(5), 8'h77);
        bus_start();
        send_byte(8'h5C, a); chk("R4 main address nack", a, 1'b0);
        bus_stop();
        addr_sel = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_alert_idle();
        logic a;
        bus_start();
        send_byte(8'h19, a); chk("R8 alert address nack while idle", a, 1'b0);
        bus_stop();
    endtask

    task automatic t_alert();
        logic a;
        logic [7:0] d;
        alert_set = 1'b1; wait_cyc(1);
        alert_set = 1'b0; wait_cyc(1);
        chk("R8 alert asserted", alert_n, 1'b0);
        bus_start();
        send_byte(8'h19, a); chk("R8 alert address ack", a, 1'b1);
        recv_byte(1'b0, d);  chk("R9 returned address", d, 8'h5C);
        bus_stop();
        chk("R9 alert withdrawn", alert_n, 1'b1);
    endtask

    task automatic t_stop_idle();
        logic a;
        send_byte(8'h5C, a); chk("R12 no ack without start", a, 1'b0);
        chk("R12 line released", sda_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        rst_n     = 1'b0;
        addr_sel  = 1'b0;
        host_scl  = 1'b1;
        host_sda  = 1'b1;
        alert_set = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_write();
        t_read();
        t_wrong_addr();
        t_strap();
        t_alert_idle();
        t_alert();
        t_stop_idle();
        chk("R10 enable changes while clock high", r10_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule